// File: doc/BRIEF.md
# Endpoint Control and Status Register

This block holds the 16-bit control and status word of one device endpoint in a full-speed USB device controller. Two agents update it. The CPU writes whole words through a single write strobe. The transaction engine reports each acknowledged transfer through event strobes. Each field reacts to a CPU write in its own way, so firmware can change one field with one read-modify-write and leave the others alone:

- The completion flags clear when written 0 and hold their value when written 1.
- The data toggles and handshake status bits flip when written 1 and hold when written 0. To reach a target value, firmware writes the current value XOR the desired value.
- The endpoint type, kind and address bits are ordinary storage.
- The setup indicator cannot be written by the CPU.

Each direction has its own handshake status, held in a small state register with four states: DISABLED, STALL, NAK and VALID. A CPU write moves it from any state to any other state through the flip rule. The named transitions are:

- Arm: NAK to VALID.
- Halt: any state to STALL.
- Shut: any state to DISABLED.
- Complete: VALID to NAK. The engine forces this on every acknowledged transfer in that direction, so firmware must re-arm the endpoint before the next packet.

The decoded state of each direction, together with the type, kind and address, goes straight to the transaction engine.

Top module: `epreg_ctrl`

## Requirements
- R1: After reset every bit of `rd_data` reads 0.
- R2: The RX completion flag (bit 15) and the TX completion flag (bit 7) clear when a CPU write carries 0 in their position. A CPU write with 1 in that position leaves the flag unchanged, so the CPU can never set a flag.
- R3: When a completion event and a CPU write of 0 to the same flag arrive in the same cycle, the flag ends up set.
- R4: The RX toggle (bit 14) and the TX toggle (bit 6) flip when a CPU write carries 1 in their position. A 0 in that position leaves them unchanged.
- R5: The RX status field (bits 13:12) and the TX status field (bits 5:4) flip each bit written as 1. The encoding is 0 = disabled, 1 = stall, 2 = NAK, 3 = valid. The `rx_stat` and `tx_stat` ports carry the same values.
- R6: A completion event on a direction sets that direction's status to NAK one cycle later. This wins over a CPU write to that field in the same cycle.
- R7: A completion event flips that direction's toggle. If the CPU also writes 1 to that toggle in the same cycle, both flips apply.
- R8: The setup bit (bit 11) is set by an RX completion that has `hw_setup` high and cleared by an RX completion that has `hw_setup` low. CPU writes never change it.
- R9: The type (bits 10:9), kind (bit 8) and address (bits 3:0) store what the CPU writes. The type encoding is 0 = bulk, 1 = control, 2 = isochronous, 3 = interrupt. These values appear on `ep_type`, `ep_kind` and `ep_addr`.
- R10: Every update appears on `rd_data` one clock after the edge that captures it. With no write and no event, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_wdata | input | 16 | CPU write word |
| rd_data | output | 16 | Current register word |
| hw_rx_done | input | 1 | Acknowledged OUT or SETUP transfer |
| hw_tx_done | input | 1 | Acknowledged IN transfer |
| hw_setup | input | 1 | Qualifies `hw_rx_done` as a SETUP transfer |
| rx_stat | output | 2 | RX handshake state |
| tx_stat | output | 2 | TX handshake state |
| rx_toggle | output | 1 | RX data toggle |
| tx_toggle | output | 1 | TX data toggle |
| ep_type | output | 2 | Endpoint type |
| ep_kind | output | 1 | Endpoint kind bit |
| ep_addr | output | 4 | Endpoint address |

## Verification
The assertions assume that `hw_setup` is high only in a cycle where `hw_rx_done` is also high. That condition is itself checked as a property. The stimulus drives `hw_setup` only together with an RX completion. It also presents CPU writes in the same cycle as engine events, which is where the priority rules for flags, toggles and status can be seen.

// File: rtl/epreg_pkg.sv
package epreg_pkg;

    typedef enum logic [1:0] {
        HS_DISABLED = 2'd0,
        HS_STALL    = 2'd1,
        HS_NAK      = 2'd2,
        HS_VALID    = 2'd3
    } hs_state_t;

    typedef enum logic [1:0] {
        EPT_BULK    = 2'd0,
        EPT_CONTROL = 2'd1,
        EPT_ISO     = 2'd2,
        EPT_INTR    = 2'd3
    } ep_type_t;

    localparam int REG_W      = 16;
    localparam int DIR_N      = 2;   // index 0 = TX, index 1 = RX
    localparam int DIR_SLICE  = 4;   // status(2) + toggle + flag
    localparam int DIR_BASE0  = 4;
    localparam int DIR_STRIDE = 8;
    localparam int SETUP_POS  = 11;
    localparam int TYPE_LO    = 9;
    localparam int KIND_POS   = 8;
    localparam int ADDR_W     = 4;

endpackage

// File: rtl/epreg_flag.sv
module epreg_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_we,
    input  logic cpu_bit,
    input  logic hw_set,
    output logic flag
);
    logic flag_q;
    logic flag_d;

    always_comb begin
        flag_d = flag_q;
        if (cpu_we && !cpu_bit) flag_d = 1'b0;
        if (hw_set)             flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

    // R2
    flag_no_cpu_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !hw_set) |=> !flag_q);

    // R3
    flag_hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set |=> flag_q);

endmodule

// File: rtl/epreg_dir.sv
module epreg_dir
    import epreg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cpu_we,
    input  logic [3:0] cpu_bits,   // {flag, toggle, status[1:0]}
    input  logic      hw_done,
    output logic      flag,
    output logic      toggle,
    output hs_state_t stat
);
    hs_state_t stat_q;
    hs_state_t stat_d;
    logic      tog_q;
    logic      tog_d;
    logic      cpu_flip_tog;

    epreg_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_we  (cpu_we),
        .cpu_bit (cpu_bits[3]),
        .hw_set  (hw_done),
        .flag    (flag)
    );

    assign cpu_flip_tog = cpu_we && cpu_bits[2];

    always_comb begin
        tog_d = tog_q ^ cpu_flip_tog ^ hw_done;
    end

    // handshake state machine: Complete wins, otherwise CPU flip moves it
    always_comb begin
        stat_d = stat_q;
        if (hw_done) begin
            stat_d = HS_NAK;
        end else if (cpu_we) begin
            unique case (stat_q)
                HS_DISABLED: stat_d = hs_state_t'(2'd0 ^ cpu_bits[1:0]);
                HS_STALL:    stat_d = hs_state_t'(2'd1 ^ cpu_bits[1:0]);
                HS_NAK:      stat_d = hs_state_t'(2'd2 ^ cpu_bits[1:0]);
                HS_VALID:    stat_d = hs_state_t'(2'd3 ^ cpu_bits[1:0]);
                default:     stat_d = HS_DISABLED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= HS_DISABLED;
            tog_q  <= 1'b0;
        end else begin
            stat_q <= stat_d;
            tog_q  <= tog_d;
        end
    end

    assign stat   = stat_q;
    assign toggle = tog_q;

    // R6
    stat_nak_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_done |=> (stat_q == HS_NAK));

    // R7
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_done && !cpu_flip_tog) |=> (tog_q != $past(tog_q)));

    // R5
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_done && !cpu_we) |=> $stable(stat_q));

endmodule

// File: rtl/epreg_fields.sv
module epreg_fields
    import epreg_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_we,
    input  logic [1:0]    wr_type,
    input  logic          wr_kind,
    input  logic [AW-1:0] wr_addr,
    output ep_type_t      ep_type,
    output logic          ep_kind,
    output logic [AW-1:0] ep_addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ep_type <= EPT_BULK;
            ep_kind <= 1'b0;
            ep_addr <= '0;
        end else if (cpu_we) begin
            ep_type <= ep_type_t'(wr_type);
            ep_kind <= wr_kind;
            ep_addr <= wr_addr;
        end
    end

    // R9
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_we |=> ($stable(ep_type) && $stable(ep_kind) && $stable(ep_addr)));

endmodule

// File: rtl/epreg_ctrl.sv
module epreg_ctrl
    import epreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_we,
    input  logic [15:0] cpu_wdata,
    output logic [15:0] rd_data,
    input  logic        hw_rx_done,
    input  logic        hw_tx_done,
    input  logic        hw_setup,
    output logic [1:0]  rx_stat,
    output logic [1:0]  tx_stat,
    output logic        rx_toggle,
    output logic        tx_toggle,
    output logic [1:0]  ep_type,
    output logic        ep_kind,
    output logic [3:0]  ep_addr
);
    logic      dir_done [DIR_N];
    logic      dir_flag [DIR_N];
    logic      dir_tog  [DIR_N];
    hs_state_t dir_stat [DIR_N];
    logic      setup_q;
    ep_type_t  type_w;
    logic      unused_wbit;

    assign dir_done[0] = hw_tx_done;
    assign dir_done[1] = hw_rx_done;
    assign unused_wbit = cpu_wdata[SETUP_POS];

    for (genvar d = 0; d < DIR_N; d++) begin : g_dir
        localparam int BASE = DIR_BASE0 + d * DIR_STRIDE;
        epreg_dir u_dir (
            .clk      (clk),
            .rst_n    (rst_n),
            .cpu_we   (cpu_we),
            .cpu_bits (cpu_wdata[BASE +: DIR_SLICE]),
            .hw_done  (dir_done[d]),
            .flag     (dir_flag[d]),
            .toggle   (dir_tog[d]),
            .stat     (dir_stat[d])
        );
    end

    epreg_fields #(.AW(ADDR_W)) u_fields (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_we  (cpu_we),
        .wr_type (cpu_wdata[TYPE_LO +: 2]),
        .wr_kind (cpu_wdata[KIND_POS]),
        .wr_addr (cpu_wdata[ADDR_W-1:0]),
        .ep_type (type_w),
        .ep_kind (ep_kind),
        .ep_addr (ep_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          setup_q <= 1'b0;
        else if (hw_rx_done) setup_q <= hw_setup;
    end

    always_comb begin
        rd_data = '0;
        for (int d = 0; d < DIR_N; d++) begin
            rd_data[DIR_BASE0 + d*DIR_STRIDE +: DIR_SLICE] =
                {dir_flag[d], dir_tog[d], dir_stat[d]};
        end
        rd_data[SETUP_POS]     = setup_q;
        rd_data[TYPE_LO +: 2]  = type_w;
        rd_data[KIND_POS]      = ep_kind;
        rd_data[ADDR_W-1:0]    = ep_addr;
    end

    assign rx_stat   = dir_stat[1];
    assign tx_stat   = dir_stat[0];
    assign rx_toggle = dir_tog[1];
    assign tx_toggle = dir_tog[0];
    assign ep_type   = type_w;

    // R8
    setup_cpu_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_rx_done |=> $stable(setup_q));

    // R8
    setup_input_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_setup |-> hw_rx_done);

endmodule

// File: tb/epreg_ctrl_bench.sv
`timescale 1ns/1ps
module epreg_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic        hw_rx_done = 1'b0;
    logic        hw_tx_done = 1'b0;
    logic        hw_setup = 1'b0;
    logic [15:0] rd_data;
    logic [1:0]  rx_stat, tx_stat, ep_type;
    logic        rx_toggle, tx_toggle, ep_kind;
    logic [3:0]  ep_addr;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    epreg_ctrl u_epreg_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
        .rd_data(rd_data), .hw_rx_done(hw_rx_done), .hw_tx_done(hw_tx_done),
        .hw_setup(hw_setup), .rx_stat(rx_stat), .tx_stat(tx_stat),
        .rx_toggle(rx_toggle), .tx_toggle(tx_toggle), .ep_type(ep_type),
        .ep_kind(ep_kind), .ep_addr(ep_addr)
    );

    // {we, wdata[15:0], rx_done, tx_done, setup, expected[15:0]}
    localparam int NV = 11;
    localparam logic [35:0] VEC [NV] = '{
        {1'b1, 16'hB2A0, 3'b000, 16'h3220}, // R9 control type, R5 RX valid, TX NAK
        {1'b0, 16'h0000, 3'b101, 16'hEA20}, // R8 setup RX completion
        {1'b1, 16'h0280, 3'b000, 16'h6A20}, // R2 clear RX flag
        {1'b1, 16'h8290, 3'b000, 16'h6A30}, // R5 arm TX
        {1'b0, 16'h0000, 3'b010, 16'h6AE0}, // R6 TX completion
        {1'b1, 16'h9200, 3'b100, 16'hA260}, // R6 NAK beats CPU, R2 TX clear
        {1'b1, 16'h0280, 3'b101, 16'hEA60}, // R3 set beats clear
        {1'b1, 16'hC5C5, 3'b000, 16'hAD25}, // R4 toggles, R9 fields
        {1'b1, 16'hB5B5, 3'b000, 16'h9D15}, // R5 stall both
        {1'b1, 16'h1595, 3'b000, 16'h0D05}, // R5 disable both, R2 clear RX
        {1'b0, 16'hFFFF, 3'b000, 16'h0D05}  // R10 hold
    };
    localparam string TAGS [NV] = '{"R9", "R8", "R2", "R5", "R6", "R6",
                                    "R3", "R4", "R5", "R5", "R10"};

    task automatic check(input string tag, input logic [15:0] got,
                         input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", rd_data, 16'h0000);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cpu_we     = VEC[i][35];
            cpu_wdata  = VEC[i][34:19];
            hw_rx_done = VEC[i][18];
            hw_tx_done = VEC[i][17];
            hw_setup   = VEC[i][16];
            @(posedge clk);
            #1;
            check(TAGS[i], rd_data, VEC[i][15:0]);
            cpu_we = 1'b0; hw_rx_done = 1'b0; hw_tx_done = 1'b0; hw_setup = 1'b0;
        end
        // R9 decoded field ports: iso type, kind set, address 5
        check("R9", {12'd0, ep_type, ep_kind, ep_kind}, {12'd0, 2'd2, 1'b1, 1'b1});
        check("R9", {12'd0, ep_addr}, 16'h0005);
        // R5 status ports after disabling both directions
        check("R5", {12'd0, rx_stat, tx_stat}, 16'h0000);
        // R7 CPU flip and completion flip together cancel on TX toggle
        @(negedge clk);
        cpu_we = 1'b1; cpu_wdata = 16'h0545; hw_tx_done = 1'b1;
        @(posedge clk); #1;
        check("R7", {14'd0, tx_toggle, tx_stat == 2'd2}, 16'h0001);
        cpu_we = 1'b0; hw_tx_done = 1'b0;
        // R8 non-setup RX completion clears setup bit, CPU write 1 cannot set it
        @(negedge clk);
        hw_rx_done = 1'b1;
        @(posedge clk); #1;
        hw_rx_done = 1'b0;
        @(negedge clk);
        cpu_we = 1'b1; cpu_wdata = 16'h8D85;
        @(posedge clk); #1;
        cpu_we = 1'b0;
        check("R8", {15'd0, rd_data[11]}, 16'h0000);
        // R1 reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", rd_data, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule